// File: doc/BRIEF.md
# Banked Branch Special-Register Unit

This unit keeps the link, count and branch-target registers together with the interrupt save and scratch registers in two eight-entry register banks, one even and one odd. The count register lives in the odd bank at the same index the link register uses in the even bank. A conditional branch can therefore, in a single pass, read the count register and write back its decremented value in the odd bank, while the even bank supplies the link or target register and takes the link write. No branch has to be issued twice.

Each valid branch presented on the instruction port yields, one clock later, a taken flag, an absolute target address and a redirect flag for the fetch side. A separate move-to-register write port lets any bank entry be loaded. Writes land in a one-entry pending register per bank before they reach storage, and a read that hits the pending entry sees the new data, so back-to-back branches that use the count or link register see each other's updates.

Top module: `brspr_unit`

## Requirements
- R1: Synchronous reset clears every entry of both banks and drives `out_valid`, `br_taken` and `redirect` low.
- R2: Only opcode 16 (`insn[31:26]`, relative branch) and opcode 19 with `insn[10:1]` equal to 16, 528 or 560 (register-target branch) count as branches. Any other valid word gives no result and changes no register.
- R3: A register-target branch takes its target from the link register (even index 5) when `insn[10]` is 0, from the count register (odd index 5) when `insn[10]` is 1 and `insn[6]` is 0, and from the target register (even index 6) otherwise. The target is absolute, with its two low bits forced to zero.
- R4: A relative branch target is the sign-extended `insn[15:2]` shifted left by two, added to `pc` when `insn[1]` is 0 or used alone when `insn[1]` is 1.
- R5: The count register is decremented only when `insn[23]` is 0 and the branch is relative or a register-target branch that does not take its target from the count register. The decrement reads odd index 5 and writes back the read value minus 1.
- R6: The branch is taken when both tests pass. The count test passes if no decrement happens, or if (decremented value is zero) equals `insn[22]`. The condition test passes if `insn[25]` is 1 or `cond_bit` equals `insn[24]`.
- R7: When `insn[0]` is 1 on a branch, `pc + 4` is written to even index 5 in the same operation as any count update.
- R8: A read of an entry written by the request of the previous cycle returns the new data.
- R9: A relative branch is predicted taken exactly when `insn[15]` is 1 and `redirect` flags a mismatch of outcome and prediction. For a register-target branch `redirect` equals `br_taken`.
- R10: The move-to-register port writes `mt_data` to index `mt_idx` of the odd bank when `mt_odd` is 1, else the even bank. A branch write to the same bank in the same cycle wins, and a branch write to the other bank does not block it.
- R11: Results appear on the clock edge after the branch is accepted, marked by a one-cycle `out_valid`. `redirect` is never high without `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word |
| pc | input | 64 | Address of the instruction |
| cond_bit | input | 1 | Condition bit selected for this branch |
| mt_en | input | 1 | Move-to-register write enable |
| mt_odd | input | 1 | Write the odd bank (1) or the even bank (0) |
| mt_idx | input | 3 | Bank entry index to write |
| mt_data | input | 64 | Data to write |
| out_valid | output | 1 | Result of the previous-cycle branch is valid |
| br_taken | output | 1 | Branch taken |
| br_target | output | 64 | Absolute target address |
| redirect | output | 1 | Fetch must be redirected |

## Verification
The assertions assume that `insn` and `pc` are only meaningful while `insn_valid` is high and that the move-to-register port and branches may overlap freely. The forwarding and decrement properties read the bank outputs in the cycle after a write, so they rely on the odd bank always being read at the count index and on the even read index being set by the following instruction. The stimulus holds every input steady between falling edges, issues branches back to back so that pending writes are hit, and places move-to-register writes both on idle cycles and in the same cycle as branch writes to either bank.

// File: rtl/brspr_pkg.sv
package brspr_pkg;

    localparam int IDX_W = 3;

    // even bank layout
    localparam logic [IDX_W-1:0] EV_SCR0   = 3'd2;
    localparam logic [IDX_W-1:0] EV_SCR2   = 3'd3;
    localparam logic [IDX_W-1:0] EV_HSCR0  = 3'd4;
    localparam logic [IDX_W-1:0] EV_LINK   = 3'd5;
    localparam logic [IDX_W-1:0] EV_TGT    = 3'd6;
    // odd bank layout; count index must match link index
    localparam logic [IDX_W-1:0] OD_SAVE1  = 3'd0;
    localparam logic [IDX_W-1:0] OD_HSAVE1 = 3'd1;
    localparam logic [IDX_W-1:0] OD_SCR1   = 3'd2;
    localparam logic [IDX_W-1:0] OD_SCR3   = 3'd3;
    localparam logic [IDX_W-1:0] OD_HSCR1  = 3'd4;
    localparam logic [IDX_W-1:0] OD_COUNT  = 3'd5;

    localparam logic [5:0] OPC_REL = 6'd16;
    localparam logic [5:0] OPC_REG = 6'd19;
    localparam logic [9:0] XO_VIA_LINK  = 10'd16;
    localparam logic [9:0] XO_VIA_COUNT = 10'd528;
    localparam logic [9:0] XO_VIA_TGT   = 10'd560;

    typedef enum logic [1:0] {
        SRC_LINK  = 2'd0,
        SRC_COUNT = 2'd1,
        SRC_TGT   = 2'd2
    } tgt_src_e;

    typedef struct packed {
        logic       is_br;
        logic       is_reg;
        logic       dec_cnt;
        logic       link;
        tgt_src_e   src;
        logic [4:0] bo;
        logic [13:0] disp;
        logic       abs_addr;
        logic       pred;
    } br_dec_t;

    function automatic logic cond_pass(input logic [4:0] bo, input logic c);
        return bo[4] | (c == bo[3]);
    endfunction

endpackage

// File: rtl/brspr_decode.sv
module brspr_decode
    import brspr_pkg::*;
(
    input  logic        insn_valid,
    input  logic [31:0] insn,
    output br_dec_t     dec
);
    logic [5:0] opc;
    logic [9:0] xo;
    logic       rel_form;
    logic       reg_form;

    assign opc = insn[31:26];
    assign xo  = insn[10:1];
    assign rel_form = (opc == OPC_REL);
    assign reg_form = (opc == OPC_REG) &&
                      (xo == XO_VIA_LINK || xo == XO_VIA_COUNT || xo == XO_VIA_TGT);

    always_comb begin
        dec.is_br    = insn_valid & (rel_form | reg_form);
        dec.is_reg   = reg_form;
        dec.link     = insn[0];
        dec.bo       = insn[25:21];
        dec.disp     = insn[15:2];
        dec.abs_addr = insn[1];
        dec.pred     = insn[15];
        if (!insn[10])
            dec.src = SRC_LINK;
        else if (!insn[6])
            dec.src = SRC_COUNT;
        else
            dec.src = SRC_TGT;
        dec.dec_cnt = ~insn[23] &
                      (rel_form | (reg_form & ~(insn[10] & ~insn[6])));
    end
endmodule

// File: rtl/brspr_bank.sv
module brspr_bank #(
    parameter int W     = 64,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [W-1:0]             wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [W-1:0]             rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  store [DEPTH];
    logic          pend_en;
    logic [AW-1:0] pend_idx;
    logic [W-1:0]  pend_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_en   <= 1'b0;
            pend_idx  <= '0;
            pend_data <= '0;
        end else begin
            pend_en   <= wr_en;
            pend_idx  <= wr_idx;
            pend_data <= wr_data;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                store[g] <= '0;
            else if (pend_en && pend_idx == AW'(g))
                store[g] <= pend_data;
        end
    end

    assign rd_data = (pend_en && pend_idx == rd_idx) ? pend_data : store[rd_idx];

    // R8
    fwd_hit_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_idx != $past(wr_idx) || rd_data == $past(wr_data)));
endmodule

// File: rtl/brspr_resolve.sv
module brspr_resolve
    import brspr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  br_dec_t         dec,
    input  logic [XLEN-1:0] pc,
    input  logic            cond_bit,
    input  logic [XLEN-1:0] ev_rd,
    input  logic [XLEN-1:0] od_rd,
    output logic [XLEN-1:0] cnt_next,
    output logic            out_valid,
    output logic            br_taken,
    output logic [XLEN-1:0] br_target,
    output logic            redirect
);
    logic            cnt_ok;
    logic            taken_c;
    logic [XLEN-1:0] reg_tgt;
    logic [XLEN-1:0] rel_off;
    logic [XLEN-1:0] tgt_c;
    logic            redir_c;
    logic            was_reg;

    assign cnt_next = od_rd - XLEN'(1);
    assign cnt_ok   = ~dec.dec_cnt | ((cnt_next == '0) == dec.bo[1]);
    assign taken_c  = cnt_ok & cond_pass(dec.bo, cond_bit);

    always_comb begin
        case (dec.src)
            SRC_COUNT: reg_tgt = od_rd;
            SRC_TGT:   reg_tgt = ev_rd;
            default:   reg_tgt = ev_rd;
        endcase
        rel_off = {{(XLEN-16){dec.disp[13]}}, dec.disp, 2'b00};
        if (dec.is_reg)
            tgt_c = {reg_tgt[XLEN-1:2], 2'b00};
        else if (dec.abs_addr)
            tgt_c = rel_off;
        else
            tgt_c = pc + rel_off;
        redir_c = dec.is_reg ? taken_c : (taken_c != dec.pred);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            br_taken  <= 1'b0;
            redirect  <= 1'b0;
            br_target <= '0;
            was_reg   <= 1'b0;
        end else begin
            out_valid <= dec.is_br;
            br_taken  <= dec.is_br & taken_c;
            redirect  <= dec.is_br & redir_c;
            was_reg   <= dec.is_reg;
            if (dec.is_br)
                br_target <= tgt_c;
        end
    end

    // R9
    reg_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && was_reg) |-> (redirect == br_taken));
endmodule

// File: rtl/brspr_unit.sv
module brspr_unit
    import brspr_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            insn_valid,
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] pc,
    input  logic            cond_bit,
    input  logic            mt_en,
    input  logic            mt_odd,
    input  logic [2:0]      mt_idx,
    input  logic [XLEN-1:0] mt_data,
    output logic            out_valid,
    output logic            br_taken,
    output logic [XLEN-1:0] br_target,
    output logic            redirect
);
    br_dec_t         dec;
    logic            br_we_e, br_we_o;
    logic            we_e, we_o;
    logic [2:0]      wi_e, wi_o, ri_e;
    logic [XLEN-1:0] wd_e, wd_o;
    logic [XLEN-1:0] rd_e, rd_o, cnt_next;

    brspr_decode u_dec (
        .insn_valid(insn_valid),
        .insn      (insn),
        .dec       (dec)
    );

    assign br_we_e = dec.is_br & dec.link;
    assign br_we_o = dec.is_br & dec.dec_cnt;

    // branch writes win over the move-to port on the same bank
    assign we_e = br_we_e | (mt_en & ~mt_odd);
    assign wi_e = br_we_e ? EV_LINK : mt_idx;
    assign wd_e = br_we_e ? (pc + XLEN'(4)) : mt_data;
    assign we_o = br_we_o | (mt_en & mt_odd);
    assign wi_o = br_we_o ? OD_COUNT : mt_idx;
    assign wd_o = br_we_o ? cnt_next : mt_data;

    assign ri_e = (dec.src == SRC_TGT) ? EV_TGT : EV_LINK;

    brspr_bank #(.W(XLEN), .DEPTH(DEPTH)) u_even (
        .clk(clk), .rst(rst),
        .wr_en(we_e), .wr_idx(wi_e), .wr_data(wd_e),
        .rd_idx(ri_e), .rd_data(rd_e)
    );

    brspr_bank #(.W(XLEN), .DEPTH(DEPTH)) u_odd (
        .clk(clk), .rst(rst),
        .wr_en(we_o), .wr_idx(wi_o), .wr_data(wd_o),
        .rd_idx(OD_COUNT), .rd_data(rd_o)
    );

    brspr_resolve #(.XLEN(XLEN)) u_res (
        .clk(clk), .rst(rst),
        .dec(dec), .pc(pc), .cond_bit(cond_bit),
        .ev_rd(rd_e), .od_rd(rd_o),
        .cnt_next(cnt_next),
        .out_valid(out_valid), .br_taken(br_taken),
        .br_target(br_target), .redirect(redirect)
    );

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.is_br && dec.dec_cnt) |=> (rd_o == $past(rd_o) - XLEN'(1)));

    // R7
    link_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.is_br && dec.link) |=> (ri_e != EV_LINK || rd_e == $past(pc) + XLEN'(4)));

    // R2
    no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && !dec.is_br && !mt_en) |=> (rd_o == $past(rd_o)));

    // R11
    result_slot_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(insn_valid));

    // R11
    redirect_gate_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |-> out_valid);
endmodule

// File: tb/brspr_unit_tb.sv
module brspr_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] pc = '0;
    logic        cond_bit = 1'b0;
    logic        mt_en = 1'b0;
    logic        mt_odd = 1'b0;
    logic [2:0]  mt_idx = '0;
    logic [63:0] mt_data = '0;
    logic        out_valid, br_taken, redirect;
    logic [63:0] br_target;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    brspr_unit u_dut (
        .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn(insn), .pc(pc),
        .cond_bit(cond_bit), .mt_en(mt_en), .mt_odd(mt_odd), .mt_idx(mt_idx),
        .mt_data(mt_data), .out_valid(out_valid), .br_taken(br_taken),
        .br_target(br_target), .redirect(redirect)
    );

    // model of bank contents
    logic [63:0] m_ev [8];
    logic [63:0] m_od [8];

    // scoreboard
    bit          q_tk [$];
    logic [63:0] q_tg [$];
    bit          q_rd [$];
    string       q_tag [$];

    function automatic logic [31:0] rel_br(input logic [4:0] bo, input logic [13:0] d,
                                           input logic aa, input logic lk);
        return {6'd16, bo, 5'd0, d, aa, lk};
    endfunction

    function automatic logic [31:0] reg_br(input logic [4:0] bo, input logic [9:0] xo,
                                           input logic lk);
        return {6'd19, bo, 5'd0, 5'd0, xo, lk};
    endfunction

    task automatic step(input logic [31:0] w, input logic v, input logic c,
                        input logic [63:0] p, input logic me, input logic mo,
                        input logic [2:0] mi, input logic [63:0] md, input string tag);
        logic [5:0] op;
        logic [9:0] xo;
        logic [4:0] bo;
        bit isrel, isreg, decr, tk, cok, ook, lk, rd;
        logic [63:0] nc, tg, off;
        @(negedge clk);
        insn_valid = v; insn = w; cond_bit = c; pc = p;
        mt_en = me; mt_odd = mo; mt_idx = mi; mt_data = md;
        op = w[31:26]; xo = w[10:1]; bo = w[25:21];
        isrel = v && op == 6'd16;
        isreg = v && op == 6'd19 && (xo == 10'd16 || xo == 10'd528 || xo == 10'd560);
        decr = 0; lk = 0;
        if (isrel || isreg) begin
            lk = w[0];
            decr = !bo[2] && !(isreg && xo == 10'd528);
            nc = m_od[5] - 64'd1;
            cok = !decr || ((nc == 64'd0) == bo[1]);
            ook = bo[4] || (c == bo[3]);
            tk = cok && ook;
            if (isreg) begin
                if (xo == 10'd16) tg = m_ev[5];
                else if (xo == 10'd528) tg = m_od[5];
                else tg = m_ev[6];
                tg[1:0] = 2'b00;
                rd = tk;
            end else begin
                off = {{48{w[15]}}, w[15:2], 2'b00};
                tg = w[1] ? off : p + off;
                rd = (tk != w[15]);
            end
            q_tk.push_back(tk); q_tg.push_back(tg); q_rd.push_back(rd); q_tag.push_back(tag);
            if (decr) m_od[5] = nc;
            if (lk) m_ev[5] = p + 64'd4;
        end
        if (me) begin
            if (mo && !decr) m_od[mi] = md;
            if (!mo && !lk) m_ev[mi] = md;
        end
    endtask

    task automatic idle();
        step(32'h0, 0, 0, 64'h0, 0, 0, 3'd0, 64'h0, "idle");
    endtask

    task automatic mt(input logic o, input logic [2:0] i, input logic [63:0] d);
        step(32'h0, 0, 0, 64'h0, 1, o, i, d, "R10 move-to");
    endtask

    task automatic br(input logic [31:0] w, input logic c, input logic [63:0] p,
                      input string tag);
        step(w, 1, c, p, 0, 0, 3'd0, 64'h0, tag);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && !done && out_valid) begin
            n_chk++;
            if (q_tk.size() == 0) begin
                n_bad++;
                $display("FAIL R11 unexpected result: out_valid=1 expected 0");
            end else begin
                bit etk, erd;
                logic [63:0] etg;
                string t;
                etk = q_tk.pop_front(); etg = q_tg.pop_front();
                erd = q_rd.pop_front(); t = q_tag.pop_front();
                if (br_taken !== etk || br_target !== etg || redirect !== erd) begin
                    n_bad++;
                    $display("FAIL %s: taken=%0b target=%h redirect=%0b expected %0b %h %0b",
                             t, br_taken, br_target, redirect, etk, etg, erd);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    localparam logic [4:0] BO_ALWAYS = 5'b10100;
    localparam logic [4:0] BO_DNZ    = 5'b10000;
    localparam logic [4:0] BO_DZ     = 5'b10010;
    localparam logic [4:0] BO_CT     = 5'b01100;

    initial begin
        for (int i = 0; i < 8; i++) begin m_ev[i] = '0; m_od[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state of the outputs
        n_chk++;
        if (out_valid !== 1'b0 || br_taken !== 1'b0 || redirect !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset outputs: %0b%0b%0b expected 000", out_valid, br_taken, redirect);
        end
        // R1 cleared banks, R3 link source
        br(reg_br(BO_ALWAYS, 10'd16, 0), 0, 64'h100, "R1 R3 link after reset");
        idle();
        // R10 R8 move-to then immediate link read
        mt(0, 3'd5, 64'h1000);
        br(reg_br(BO_ALWAYS, 10'd16, 0), 0, 64'h100, "R8 R3 link forwarded");
        // R3 target register, low bits cleared
        mt(0, 3'd6, 64'h2003);
        idle();
        br(reg_br(BO_ALWAYS, 10'd560, 0), 0, 64'h100, "R3 target register");
        // R5 R6 R8 R9 count loop, backward displacement
        mt(1, 3'd5, 64'd3);
        br(rel_br(BO_DNZ, 14'h3FFF, 0, 0), 0, 64'h400, "R5 R6 dnz 3");
        br(rel_br(BO_DNZ, 14'h3FFF, 0, 0), 0, 64'h400, "R8 R6 dnz 2");
        br(rel_br(BO_DNZ, 14'h3FFF, 0, 0), 0, 64'h400, "R9 R6 dnz 1");
        // R6 zero test on wrap, then on reaching zero
        br(rel_br(BO_DZ, 14'h0010, 0, 0), 0, 64'h500, "R6 dz wrap");
        mt(1, 3'd5, 64'd1);
        br(rel_br(BO_DZ, 14'h0010, 0, 0), 0, 64'h500, "R6 R9 dz taken");
        // R7 decrement and link together
        mt(1, 3'd5, 64'd5);
        br(rel_br(BO_DNZ, 14'h0004, 0, 1), 0, 64'h800, "R7 R5 dnz link");
        br(reg_br(BO_ALWAYS, 10'd16, 0), 0, 64'h900, "R7 R8 link value");
        br(reg_br(BO_ALWAYS, 10'd528, 0), 0, 64'h900, "R5 R3 count value");
        // R5 count-target form never decrements
        br(reg_br(5'b00000, 10'd528, 0), 0, 64'h900, "R5 count-target no dec");
        br(reg_br(BO_ALWAYS, 10'd528, 0), 0, 64'h900, "R5 count unchanged");
        // R6 R9 condition test, forward displacement
        br(rel_br(BO_CT, 14'h0020, 0, 0), 0, 64'hA00, "R6 cond miss");
        br(rel_br(BO_CT, 14'h0020, 0, 0), 1, 64'hA00, "R6 R9 cond hit");
        // R4 absolute relative-form target
        br(rel_br(BO_ALWAYS, 14'h0100, 1, 0), 0, 64'hB00, "R4 absolute");
        br(rel_br(BO_ALWAYS, 14'h3FF0, 0, 0), 0, 64'hB00, "R4 relative back");
        // R10 same-bank conflict: branch wins; other bank write proceeds
        step(rel_br(BO_ALWAYS, 14'h0001, 0, 1), 1, 0, 64'hC00, 1, 0, 3'd5, 64'hDEAD0,
             "R10 conflict branch");
        br(reg_br(BO_ALWAYS, 10'd16, 0), 0, 64'hC10, "R10 link kept branch value");
        step(rel_br(BO_ALWAYS, 14'h0001, 0, 1), 1, 0, 64'hD00, 1, 1, 3'd5, 64'h40,
             "R10 other bank branch");
        br(reg_br(BO_ALWAYS, 10'd528, 0), 0, 64'hD10, "R10 count written by port");
        // R2 non-branch words
        step(reg_br(BO_ALWAYS, 10'd150, 1), 1, 0, 64'hE00, 0, 0, 3'd0, 64'h0, "R2 nb");
        @(negedge clk);
        insn_valid = 0;
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R2 non-branch result: out_valid=%0b expected 0", out_valid);
        end
        br(reg_br(BO_ALWAYS, 10'd16, 0), 0, 64'hE10, "R2 link untouched");
        // R5 link-target form decrements the count
        br(reg_br(BO_DNZ, 10'd16, 0), 0, 64'hF00, "R5 link-target dnz");
        br(reg_br(BO_ALWAYS, 10'd528, 0), 0, 64'hF00, "R5 count after link-target dnz");
        idle();
        idle();
        n_chk++;
        if (q_tk.size() != 0) begin
            n_bad++;
            $display("FAIL R11 missing results: %0d left expected 0", q_tk.size());
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule